// File: doc/BRIEF.md
# Tagged Search Result Return Pipeline

This block sits between a host command path and a cascade of lookup devices. Each time a search is issued, it records the host's tag and the search mode. When that search's result is due, it samples the index presented by the cascade and drives the index, a one-cycle valid strobe and the original tag onto the result port. Longest-prefix searches and exact-match searches take different fixed numbers of cycles. Both are tracked in one shared delay line, so results always leave in the order the searches were issued.

The same result port also carries next-free-address reads. A read is returned on the edge after it is accepted. When a read and a search result need the port on the same edge, the read wins. The search result is discarded and counted in a saturating drop counter. A low `enable` stops new issues and reads from being accepted. It does not stop searches already in flight from draining out. A search whose mode differs from the searches still in flight is refused, so the two latencies can never reorder results.

Top module: `tag_result_ret`

## Requirements
- R1: A longest-prefix search (`issue_exact`=0) accepted at rising edge k gives `index_valid`=1 in the cycle after edge k+8. In that cycle `index_out` equals the `casc_idx` sampled at edge k+8 and `tag_out` equals the tag given at issue.
- R2: An exact-match search (`issue_exact`=1) accepted at edge k gives its result in the cycle after edge k+6. The index and tag are formed as in R1, with `casc_idx` sampled at edge k+6.
- R3: Results leave in issue order. Searches of one mode accepted on consecutive edges return on consecutive cycles, each with its own tag.
- R4: A next-free-address read (`nfa_rd`=1 with `enable`=1) sampled at edge k gives `index_valid`=1, `index_out`=`nfa_addr` and `tag_out`=0 in the cycle after edge k.
- R5: If a read is accepted on the edge where a search result is due, the read is output and the search result is lost. In that case `drop_count` rises by one and holds at its all-ones maximum. In all other cases `drop_count` does not change.
- R6: `index_valid` is high for exactly one cycle per returned value and low in every cycle where no read or result was delivered.
- R7: While `enable`=0, `issue_vld` and `nfa_rd` are ignored. Searches already accepted still return at their due cycles.
- R8: A search is in flight from its accepting edge up to and including its due edge. An issue whose mode differs from the in-flight searches is refused and never produces a result. Once nothing is in flight, an issue of either mode is accepted.
- R9: After reset, `index_valid`=0, `index_out`=0, `tag_out`=0 and `drop_count`=0, and the current mode is longest-prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Accept issues and reads this cycle when high |
| issue_vld | input | 1 | A search is issued this cycle |
| issue_exact | input | 1 | Mode of the issued search: 1 exact match, 0 longest prefix |
| issue_tag | input | TAG_W (4) | Host tag carried with the search |
| nfa_rd | input | 1 | Next-free-address read request |
| nfa_addr | input | IDX_W (24) | Next free address from the cascade |
| casc_idx | input | IDX_W (24) | Search index presented by the cascade |
| index_out | output | IDX_W (24) | Returned index or address |
| index_valid | output | 1 | One-cycle strobe for each returned value |
| tag_out | output | TAG_W (4) | Tag of the returned search, 0 for reads |
| drop_count | output | DROP_W (8) | Saturating count of discarded search results |

## Verification
Each result has a fixed due time:
- an address read shows after the next edge;
- an exact-match result shows after the sixth edge from its issue;
- a longest-prefix result shows after the eighth edge.

The bench keeps a queue of accepted searches, each stamped with its due edge number. At every edge it works out which value should own the port, including refused issues and reads that pre-empt a result. It then compares `index_valid` and `drop_count` one time unit after every edge, and checks index and tag whenever a value is expected. The cascade index changes on every edge, so a result sampled one edge early or late shows up as a wrong index.

// File: rtl/trr_pkg.sv
package trr_pkg;

   typedef enum logic {
      MODE_LPM   = 1'b0,
      MODE_EXACT = 1'b1
   } srch_mode_e;

   // stage at which the shorter-latency search joins the shared delay line
   function automatic int join_stage(input int lat_long, input int lat_short);
      return lat_long - lat_short;
   endfunction

endpackage

// File: rtl/trr_mode_gate.sv
module trr_mode_gate
   import trr_pkg::*;
#(
   parameter bit SAME_LAT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic issue_vld,
   input  logic issue_exact,
   input  logic busy,
   output logic push_long,
   output logic push_short
);

   srch_mode_e cur_mode_q;
   srch_mode_e req_mode;
   logic       accept;

   assign req_mode = srch_mode_e'(issue_exact);

   generate
      if (SAME_LAT) begin : g_free
         // equal latencies cannot reorder, every issue is taken
         assign accept = enable & issue_vld;
      end else begin : g_frozen
         assign accept = enable & issue_vld & (~busy | (req_mode == cur_mode_q));
      end
   endgenerate

   assign push_long  = accept & (req_mode == MODE_LPM);
   assign push_short = accept & (req_mode == MODE_EXACT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_mode_q <= MODE_LPM;
      end else if (accept) begin
         cur_mode_q <= req_mode;
      end
   end

   // R8: the mode only moves on an edge where nothing was in flight
   p_mode_frozen_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!SAME_LAT && !$stable(cur_mode_q)) |-> !$past(busy));

endmodule

// File: rtl/trr_delay_line.sv
module trr_delay_line #(
   parameter int DEPTH  = 8,
   parameter int JOIN   = 2,
   parameter int TAG_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_long,
   input  logic             push_short,
   input  logic [TAG_W-1:0] push_tag,
   output logic             out_vld,
   output logic [TAG_W-1:0] out_tag,
   output logic             busy
);

   logic [DEPTH-1:0] vld_q, vld_d;
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TAG_W-1:0] tag_d [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0 && JOIN == 0) begin : g_head_join
            assign vld_d[i] = push_long | push_short;
            assign tag_d[i] = push_tag;
         end else if (i == 0) begin : g_head
            assign vld_d[i] = push_long;
            assign tag_d[i] = push_tag;
         end else if (i == JOIN) begin : g_join
            assign vld_d[i] = vld_q[i-1] | push_short;
            assign tag_d[i] = push_short ? push_tag : tag_q[i-1];
         end else begin : g_shift
            assign vld_d[i] = vld_q[i-1];
            assign tag_d[i] = tag_q[i-1];
         end
      end

      if (JOIN > 0) begin : g_join_chk
         // R3: a joining search never lands on an occupied slot
         p_no_collide_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            push_short |-> !vld_q[JOIN-1]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
      end else begin
         vld_q <= vld_d;
         for (int i = 0; i < DEPTH; i++) tag_q[i] <= tag_d[i];
      end
   end

   assign out_vld = vld_q[DEPTH-1];
   assign out_tag = tag_q[DEPTH-1];
   assign busy    = |vld_q;

endmodule

// File: rtl/trr_out_arb.sv
module trr_out_arb #(
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 24,
   parameter int DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nfa_take,
   input  logic [IDX_W-1:0]  nfa_addr,
   input  logic              res_vld,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [IDX_W-1:0]  casc_idx,
   output logic [IDX_W-1:0]  index_out,
   output logic              index_valid,
   output logic [TAG_W-1:0]  tag_out,
   output logic [DROP_W-1:0] drop_count
);

   localparam logic [DROP_W-1:0] DROP_MAX = '1;

   logic collide;
   assign collide = nfa_take & res_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_out   <= '0;
         index_valid <= 1'b0;
         tag_out     <= '0;
      end else if (nfa_take) begin
         index_out   <= nfa_addr;
         index_valid <= 1'b1;
         tag_out     <= '0;
      end else if (res_vld) begin
         index_out   <= casc_idx;
         index_valid <= 1'b1;
         tag_out     <= res_tag;
      end else begin
         index_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_count <= '0;
      end else if (collide && drop_count != DROP_MAX) begin
         drop_count <= drop_count + 1'b1;
      end
   end

   // R4: an accepted read owns the port on the next cycle
   p_read_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      nfa_take |=> (index_valid && index_out == $past(nfa_addr) && tag_out == '0));

   // R5: a collision below the ceiling adds exactly one drop
   p_drop_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (collide && drop_count != DROP_MAX) |=> drop_count == $past(drop_count) + 1'b1);

   // R5: no collision, no change in the drop count
   p_drop_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !collide |=> $stable(drop_count));

   // R6: each strobe follows a read or a due result
   p_strobe_cause_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!nfa_take && !res_vld) |=> !index_valid);

endmodule

// File: rtl/tag_result_ret.sv
module tag_result_ret
   import trr_pkg::*;
#(
   parameter int TAG_W     = 4,
   parameter int IDX_W     = 24,
   parameter int LAT_LPM   = 8,
   parameter int LAT_EXACT = 6,
   parameter int DROP_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              issue_vld,
   input  logic              issue_exact,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic              nfa_rd,
   input  logic [IDX_W-1:0]  nfa_addr,
   input  logic [IDX_W-1:0]  casc_idx,
   output logic [IDX_W-1:0]  index_out,
   output logic              index_valid,
   output logic [TAG_W-1:0]  tag_out,
   output logic [DROP_W-1:0] drop_count
);

   localparam int DEPTH    = LAT_LPM;
   localparam int JOIN     = join_stage(LAT_LPM, LAT_EXACT);
   localparam bit SAME_LAT = (JOIN == 0);

   initial begin
      chk_lat : assert (LAT_EXACT >= 1 && LAT_EXACT <= LAT_LPM)
         else $error("exact latency must lie in 1..LAT_LPM");
      chk_width : assert (TAG_W >= 1 && IDX_W >= 1 && DROP_W >= 1)
         else $error("widths must be positive");
   end

   logic             push_long, push_short, busy;
   logic             res_vld;
   logic [TAG_W-1:0] res_tag;
   logic             nfa_take;

   assign nfa_take = enable & nfa_rd;

   trr_mode_gate #(
      .SAME_LAT (SAME_LAT)
   ) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .issue_vld   (issue_vld),
      .issue_exact (issue_exact),
      .busy        (busy),
      .push_long   (push_long),
      .push_short  (push_short)
   );

   trr_delay_line #(
      .DEPTH (DEPTH),
      .JOIN  (JOIN),
      .TAG_W (TAG_W)
   ) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_long  (push_long),
      .push_short (push_short),
      .push_tag   (issue_tag),
      .out_vld    (res_vld),
      .out_tag    (res_tag),
      .busy       (busy)
   );

   trr_out_arb #(
      .TAG_W  (TAG_W),
      .IDX_W  (IDX_W),
      .DROP_W (DROP_W)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .nfa_take    (nfa_take),
      .nfa_addr    (nfa_addr),
      .res_vld     (res_vld),
      .res_tag     (res_tag),
      .casc_idx    (casc_idx),
      .index_out   (index_out),
      .index_valid (index_valid),
      .tag_out     (tag_out),
      .drop_count  (drop_count)
   );

   // R7: with enable low nothing new enters the line
   p_gated_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !(push_long || push_short));

   // R1, R2: a due result always reaches the port unless a read is taken
   p_result_out_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !nfa_take) |=> (index_valid && tag_out == $past(res_tag)));

endmodule

// File: tb/tag_result_ret_tb_top.sv
module tag_result_ret_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DROP_W     = 3;
   localparam int DMAX       = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, issue_vld = 1'b0, issue_exact = 1'b0, nfa_rd = 1'b0;
   logic [3:0]  issue_tag = '0;
   logic [23:0] nfa_addr = '0, casc_idx = '0;
   logic [23:0] index_out;
   logic        index_valid;
   logic [3:0]  tag_out;
   logic [DROP_W-1:0] drop_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   tag_result_ret #(.DROP_W(DROP_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .issue_vld(issue_vld),
      .issue_exact(issue_exact), .issue_tag(issue_tag), .nfa_rd(nfa_rd),
      .nfa_addr(nfa_addr), .casc_idx(casc_idx), .index_out(index_out),
      .index_valid(index_valid), .tag_out(tag_out), .drop_count(drop_count)
   );

   int    n_chk = 0, n_fail = 0, edge_n = 0;
   bit    done = 0;
   string phase = "R9";

   // reference model state
   int       due_q[$];
   bit [3:0] tag_q[$];
   bit       mode_q[$];
   bit       model_mode = 0;
   int       exp_d = 0;
   bit       exp_v;
   bit [23:0] exp_i;
   bit [3:0]  exp_t;
   string     exp_src;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] edge %0d %s: actual %h expected %h", req, phase, edge_n, what, act, expv);
      end
   endtask

   task automatic step(input bit iv, input bit ix, input bit [3:0] it,
                       input bit nr, input bit [23:0] na, input bit en);
      bit [23:0] cv;
      bit due, busy;
      cv = 24'((edge_n * 499 + 90) ^ (edge_n << 9));
      enable = en; issue_vld = iv; issue_exact = ix; issue_tag = it;
      nfa_rd = nr; nfa_addr = na; casc_idx = cv;
      due  = (due_q.size() > 0) && (due_q[0] == edge_n);
      busy = (due_q.size() > 0);
      if (en && nr) begin
         exp_v = 1; exp_i = na; exp_t = 0; exp_src = "R4";
         if (due) begin
            exp_src = "R5";
            if (exp_d < DMAX) exp_d++;
         end
      end else if (due) begin
         exp_v = 1; exp_i = cv; exp_t = tag_q[0];
         exp_src = mode_q[0] ? "R2" : "R1";
      end else begin
         exp_v = 0; exp_src = "R6";
      end
      if (due) begin
         void'(due_q.pop_front()); void'(tag_q.pop_front()); void'(mode_q.pop_front());
      end
      if (en && iv && (!busy || ix == model_mode)) begin
         due_q.push_back(edge_n + (ix ? 6 : 8));
         tag_q.push_back(it);
         mode_q.push_back(ix);
         model_mode = ix;
      end
      @(posedge clk);
      edge_n++;
      #1;
      check(index_valid == exp_v, exp_src, "index_valid", index_valid, exp_v);
      if (exp_v) begin
         check(index_out == exp_i && tag_out == exp_t, exp_src, "index/tag",
               {index_out, tag_out}, {exp_i, exp_t});
      end
      check(drop_count == DROP_W'(exp_d), "R5", "drop_count", drop_count, exp_d);
   endtask

   task automatic idle(input int n, input bit en);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, en);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9: reset values
      check(index_valid == 0 && index_out == 0 && tag_out == 0, "R9", "outputs",
            {index_valid, index_out, tag_out}, 0);
      check(drop_count == 0, "R9", "drop_count", drop_count, 0);
      rst_n = 1'b1;
      idle(2, 1);

      phase = "R1";
      step(1, 0, 4'hA, 0, 0, 1);
      idle(10, 1);

      phase = "R2";
      step(1, 1, 4'h5, 0, 0, 1);
      idle(8, 1);

      phase = "R3";
      for (int i = 0; i < 8; i++) step(1, 1, 4'(i + 3), 0, 0, 1);
      idle(8, 1);
      for (int i = 0; i < 10; i++) step(1, 0, 4'(15 - i), 0, 0, 1);
      idle(10, 1);

      phase = "R4";
      step(0, 0, 0, 1, 24'h12_3456, 1);
      step(0, 0, 0, 1, 24'hFE_DCBA, 1);
      idle(2, 1);

      phase = "R5";
      for (int k = 0; k < 10; k++) begin
         step(1, 0, 4'(k), 0, 0, 1);
         idle(7, 1);
         step(0, 0, 0, 1, 24'(k * 4099 + 7), 1);
         idle(1, 1);
      end

      phase = "R7";
      step(1, 0, 4'h9, 0, 0, 1);
      for (int i = 0; i < 12; i++) step(1, 1, 4'h3, 1, 24'h77_0000, 0);
      idle(2, 1);

      phase = "R8";
      step(1, 0, 4'h1, 0, 0, 1);
      step(1, 1, 4'h2, 0, 0, 1);
      idle(6, 1);
      step(1, 1, 4'h4, 0, 0, 1);
      step(1, 0, 4'h6, 0, 0, 1);
      idle(6, 1);
      step(1, 1, 4'h8, 0, 0, 1);
      idle(8, 1);

      phase = "mixed";
      for (int i = 0; i < 600; i++) begin
         step($urandom_range(0, 2) != 0, $urandom_range(0, 5) == 0, 4'($urandom_range(0, 15)),
              $urandom_range(0, 6) == 0, 24'($urandom), $urandom_range(0, 7) != 0);
      end
      idle(10, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule